// File: doc/BRIEF.md
# PWM Compare Output Waveform Unit

This block is a 16-bit counter with three compare channels (A, B, C). Each channel drives one output pin. A shared 4-bit waveform selector puts the counter in one of three classes. Single-slope PWM counts from 0 up to a programmable TOP and wraps. Dual-slope PWM counts up to TOP and then back down to 0. Idle stops all compare action.

Each channel has a 2-bit output action field and a 16-bit compare value. The action field chooses how the channel uses compare events:

- set or clear the pin,
- toggle the pin (channel A only, and only in some waveform selections), or
- release the pin to a fallback port value.

When a channel is connected, its output-enable is driven high. Compare values pass through a buffer, so a new value never takes effect in the middle of a period.

Field encodings:

- Channel i (A=0, B=1, C=2) uses action bits `cmp_mode[2i+1:2i]`, compare bits `cmp_val[16i+15:16i]` and `port_val[i]`.
- Waveform selections 5, 6, 7, 14 and 15 are single-slope.
- Waveform selections 1, 2, 3, 8, 9, 10 and 11 are dual-slope.
- Waveform selections 0, 4, 12 and 13 are idle.

The pin register updates at the clock edge where the counter holds the event value. The new pin level is visible from the following cycle.

Top module: `wgen_pwm_unit`

## Requirements
- R1: A channel is disconnected when any of these holds: its action field is 00; its action field is 01 and toggle is not allowed for it; the waveform selection is idle. A disconnected channel drives `pin_oe` low and `pin_out` equal to its `port_val` bit. A connected channel drives `pin_oe` high and `pin_out` from its pin register.
- R2: In single-slope and idle selections the counter steps 0,1,…,TOP,0,… . In dual-slope it steps 0,1,…,TOP,TOP-1,…,1,0,1,… . TOP is at least 1.
- R3: Single-slope, action 10: a compare match clears the pin and the counter at 0 sets it. When both events fall in the same cycle (compare value 0), the match wins.
- R4: Single-slope, action 11: a compare match sets the pin and the counter at 0 clears it. A match at 0 wins.
- R5: Single-slope, action field with bit 1 set and compare value equal to TOP: the match at TOP is ignored, but the action at 0 still takes place. This gives a constant high output for action 10 and a constant low output for action 11.
- R6: Dual-slope, action 10: a match while the counter heads upward clears the pin, and a match while it heads downward sets it. A match at TOP counts as downward and a match at 0 counts as upward.
- R7: Dual-slope, action 11: a match while heading upward sets the pin, and a match while heading downward clears it.
- R8: Action 01 toggles channel A on every match, but only in waveform selection 15 (single-slope) or 9 and 11 (dual-slope). In any other selection channel A is disconnected. Channels B and C are always disconnected with action 01.
- R9: The compare value each channel uses is copied from `cmp_val` at the clock edge where the counter equals TOP. A change at any other time has no effect until the following period.
- R10: While `rst_n` is low, the counter is 0 and heading upward, every pin register is 0, and every buffered compare value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wgm | input | 4 | Waveform selection |
| top_val | input | 16 | Counter turning value TOP |
| cmp_mode | input | 6 | Per-channel output action fields, 2 bits each |
| cmp_val | input | 48 | Per-channel compare values, 16 bits each |
| port_val | input | 3 | Fallback pin values for disconnected channels |
| pin_out | output | 3 | Pin values |
| pin_oe | output | 3 | Pin output-enables |

## Verification
Faults can sit in three places: the counter, the direction flag and the compare buffer. A wrong counter value or direction flag moves a pin edge within one period, which changes the measured high-time over a two-period window. A stale or early-loaded compare buffer shows within one period after a mid-period compare write, as a glitch edge or a missed edge. A wrong connection decision is visible at `pin_oe` in the very cycle the fields are applied.

// File: rtl/wgen_pkg.sv
package wgen_pkg;
  typedef enum logic [1:0] {
    WK_IDLE   = 2'd0,
    WK_SINGLE = 2'd1,
    WK_DUAL   = 2'd2
  } wave_kind_e;

  function automatic wave_kind_e wave_kind(input logic [3:0] sel);
    case (sel)
      4'd5, 4'd6, 4'd7, 4'd14, 4'd15:               return WK_SINGLE;
      4'd1, 4'd2, 4'd3, 4'd8, 4'd9, 4'd10, 4'd11:   return WK_DUAL;
      default:                                      return WK_IDLE;
    endcase
  endfunction

  // selections in which channel A may toggle on a match
  function automatic logic toggle_allowed(input logic [3:0] sel);
    return (sel == 4'd15) || (sel == 4'd9) || (sel == 4'd11);
  endfunction
endpackage

// File: rtl/wgen_counter.sv
module wgen_counter
  import wgen_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  wave_kind_e    kind,
  input  logic [CW-1:0] top_val,
  output logic [CW-1:0] cnt,
  output logic          going_up,
  output logic          at_top,
  output logic          at_bottom
);
  logic up_q;

  function automatic logic [CW-1:0] step(input logic [CW-1:0] c, input logic [CW-1:0] t,
                                         input wave_kind_e k, input logic up);
    if (t == '0)            return '0;
    else if (k != WK_DUAL)  return (c == t) ? '0 : c + 1'b1;
    else                    return up ? c + 1'b1 : c - 1'b1;
  endfunction

  assign at_top    = (cnt == top_val);
  assign at_bottom = (cnt == '0);

  always_comb begin
    if (kind != WK_DUAL) going_up = 1'b1;
    else if (at_bottom)  going_up = 1'b1;
    else if (at_top)     going_up = 1'b0;
    else                 going_up = up_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      up_q <= 1'b1;
    end else begin
      cnt  <= step(cnt, top_val, kind, going_up);
      up_q <= going_up;
    end
  end

  p_single_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (kind != WK_DUAL && at_top) |=> (cnt == '0));
  p_dual_turn_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == WK_DUAL && at_top && top_val != '0) |=> (cnt == $past(cnt) - 1'b1));
  p_dual_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == WK_DUAL && at_bottom && top_val != '0) |=> (cnt == CW'(1)));
endmodule

// File: rtl/wgen_channel.sv
module wgen_channel
  import wgen_pkg::*;
#(
  parameter int CW   = 16,
  parameter bit IS_A = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  wave_kind_e    kind,
  input  logic          tog_ok,
  input  logic [1:0]    mode,
  input  logic [CW-1:0] cmp_in,
  input  logic          port_bit,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] top_val,
  input  logic          going_up,
  input  logic          at_top,
  input  logic          at_bottom,
  output logic          pin_out,
  output logic          pin_oe
);
  logic [CW-1:0] ocr_q;
  logic          pin_q, pin_d;
  logic          ev_match, ev_tog, connected;

  assign ev_match  = (cnt == ocr_q);
  assign ev_tog    = IS_A && (mode == 2'b01) && tog_ok && (kind != WK_IDLE) && ev_match;
  assign connected = (kind != WK_IDLE) && (mode[1] || (IS_A && mode == 2'b01 && tog_ok));

  always_comb begin
    pin_d = pin_q;
    if (kind == WK_SINGLE && mode[1]) begin
      if (ev_match && ocr_q != top_val) pin_d = mode[0];
      else if (at_bottom)               pin_d = ~mode[0];
    end else if (kind == WK_DUAL && mode[1]) begin
      if (ev_match) pin_d = going_up ? mode[0] : ~mode[0];
    end
    if (ev_tog) pin_d = ~pin_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ocr_q <= '0;
      pin_q <= 1'b0;
    end else begin
      if (at_top) ocr_q <= cmp_in;
      pin_q <= pin_d;
    end
  end

  assign pin_out = connected ? pin_q : port_bit;
  assign pin_oe  = connected;

  p_bottom_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == WK_SINGLE && mode == 2'b10 && at_bottom && !ev_match) |=> pin_q);
  p_bottom_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == WK_SINGLE && mode == 2'b11 && at_bottom && !ev_match) |=> !pin_q);
  p_ignore_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == WK_SINGLE && mode[1] && ev_match && ocr_q == top_val && !at_bottom)
      |=> (pin_q == $past(pin_q)));
  p_dual_up_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == WK_DUAL && mode == 2'b10 && ev_match && going_up) |=> !pin_q);
  p_dual_up_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == WK_DUAL && mode == 2'b11 && ev_match && going_up) |=> pin_q);

  generate
    if (IS_A) begin : g_tog_chk
      p_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tog |=> (pin_q != $past(pin_q)));
    end
  endgenerate
endmodule

// File: rtl/wgen_pwm_unit.sv
module wgen_pwm_unit
  import wgen_pkg::*;
#(
  parameter int CW  = 16,
  parameter int NCH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        wgm,
  input  logic [CW-1:0]     top_val,
  input  logic [2*NCH-1:0]  cmp_mode,
  input  logic [NCH*CW-1:0] cmp_val,
  input  logic [NCH-1:0]    port_val,
  output logic [NCH-1:0]    pin_out,
  output logic [NCH-1:0]    pin_oe
);
  wave_kind_e    kind;
  logic          tog_ok;
  logic [CW-1:0] cnt;
  logic          going_up, at_top, at_bottom;

  assign kind   = wave_kind(wgm);
  assign tog_ok = toggle_allowed(wgm);

  wgen_counter #(.CW(CW)) i_counter (
    .clk(clk), .rst_n(rst_n), .kind(kind), .top_val(top_val),
    .cnt(cnt), .going_up(going_up), .at_top(at_top), .at_bottom(at_bottom)
  );

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      wgen_channel #(.CW(CW), .IS_A(i == 0)) i_channel (
        .clk(clk), .rst_n(rst_n), .kind(kind), .tog_ok(tog_ok),
        .mode(cmp_mode[2*i +: 2]), .cmp_in(cmp_val[CW*i +: CW]),
        .port_bit(port_val[i]), .cnt(cnt), .top_val(top_val),
        .going_up(going_up), .at_top(at_top), .at_bottom(at_bottom),
        .pin_out(pin_out[i]), .pin_oe(pin_oe[i])
      );
    end
  endgenerate
endmodule

// File: tb/test_wgen_pwm_unit.sv
module test_wgen_pwm_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  wgm = '0;
  logic [15:0] top_val = 16'd9;
  logic [5:0]  cmp_mode = '0;
  logic [47:0] cmp_val = '0;
  logic [2:0]  port_val = '0;
  logic [2:0]  pin_out, pin_oe;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  wgen_pwm_unit i_wgen_pwm_unit (
    .clk(clk), .rst_n(rst_n), .wgm(wgm), .top_val(top_val), .cmp_mode(cmp_mode),
    .cmp_val(cmp_val), .port_val(port_val), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // ---------------- reference model, built from the requirements ----------------
  logic [15:0] m_cnt;
  logic        m_rise;
  logic [15:0] m_cmp [3];
  logic [2:0]  m_pin;

  function automatic bit is_single(input logic [3:0] s);
    return s inside {4'd5, 4'd6, 4'd7, 4'd14, 4'd15};
  endfunction
  function automatic bit is_dual(input logic [3:0] s);
    return s inside {4'd1, 4'd2, 4'd3, 4'd8, 4'd9, 4'd10, 4'd11};
  endfunction
  function automatic bit may_toggle(input int ch, input logic [3:0] s);
    return ch == 0 && (s == 4'd15 || s == 4'd9 || s == 4'd11);
  endfunction
  function automatic bit linked(input int ch, input logic [3:0] s, input logic [1:0] f);
    if (!is_single(s) && !is_dual(s)) return 0;
    if (f == 2'b00) return 0;
    if (f == 2'b01) return may_toggle(ch, s);
    return 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt <= 0; m_rise <= 1;
      for (int c = 0; c < 3; c++) m_cmp[c] <= 0;
      m_pin <= 0;
    end else begin
      automatic bit up = 1;
      if (is_dual(wgm)) up = (m_cnt == 0) ? 1 : (m_cnt == top_val) ? 0 : m_rise;
      m_rise <= up;
      if (is_dual(wgm)) m_cnt <= up ? m_cnt + 1 : m_cnt - 1;
      else              m_cnt <= (m_cnt == top_val) ? 16'd0 : m_cnt + 1;
      for (int c = 0; c < 3; c++) begin
        automatic logic [1:0] f = cmp_mode[2*c +: 2];
        automatic bit hit = (m_cnt == m_cmp[c]);
        if (m_cnt == top_val) m_cmp[c] <= cmp_val[16*c +: 16];
        if (f == 2'b01) begin
          if (hit && may_toggle(c, wgm) && (is_single(wgm) || is_dual(wgm))) m_pin[c] <= ~m_pin[c];
        end else if (f[1] && is_single(wgm)) begin
          if (hit && m_cmp[c] != top_val) m_pin[c] <= (f == 2'b11);
          else if (m_cnt == 0)            m_pin[c] <= (f == 2'b10);
        end else if (f[1] && is_dual(wgm)) begin
          if (hit) m_pin[c] <= (up ^ (f == 2'b10));
        end
      end
    end
  end

  function automatic logic [2:0] ref_out();
    logic [2:0] r;
    for (int c = 0; c < 3; c++) r[c] = linked(c, wgm, cmp_mode[2*c +: 2]) ? m_pin[c] : port_val[c];
    return r;
  endfunction
  function automatic logic [2:0] ref_oe();
    logic [2:0] r;
    for (int c = 0; c < 3; c++) r[c] = linked(c, wgm, cmp_mode[2*c +: 2]);
    return r;
  endfunction

  function automatic string rq(input int n);
    case (n)
      1: return "R1"; 2: return "R2"; 3: return "R3"; 4: return "R4"; 5: return "R5";
      6: return "R6"; 7: return "R7"; 8: return "R8"; 9: return "R9"; default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- vector table ----------------
  typedef struct packed {
    logic [3:0]  sel;
    logic [15:0] top;
    logic [5:0]  fld;   // {C,B,A}
    logic [15:0] ca, cb, cc;
    logic [2:0]  port;
    int          hi_a;  // expected high cycles of pin A over window, -1 = model only
    int          req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VT [NV] = '{
    '{4'd14, 16'd9, 6'b001110, 16'd3, 16'd3, 16'd0, 3'b000,  6, 3},
    '{4'd14, 16'd9, 6'b111010, 16'd0, 16'd9, 16'd9, 3'b000,  0, 3},
    '{4'd14, 16'd9, 6'b101110, 16'd9, 16'd0, 16'd5, 3'b000, 20, 5},
    '{4'd14, 16'd9, 6'b000011, 16'd9, 16'd0, 16'd0, 3'b000,  0, 5},
    '{4'd14, 16'd9, 6'b110011, 16'd0, 16'd0, 16'd4, 3'b010, 20, 4},
    '{4'd5,  16'd5, 6'b000011, 16'd2, 16'd0, 16'd0, 3'b000,  8, 4},
    '{4'd15, 16'd9, 6'b100101, 16'd4, 16'd3, 16'd2, 3'b010, 10, 8},
    '{4'd14, 16'd9, 6'b000101, 16'd4, 16'd4, 16'd0, 3'b011, 20, 1},
    '{4'd10, 16'd9, 6'b101110, 16'd3, 16'd6, 16'd9, 3'b000, 12, 6},
    '{4'd10, 16'd9, 6'b001010, 16'd9, 16'd0, 16'd0, 3'b000, 36, 6},
    '{4'd8,  16'd9, 6'b110011, 16'd3, 16'd0, 16'd0, 3'b000, 24, 7},
    '{4'd9,  16'd9, 6'b001001, 16'd4, 16'd4, 16'd0, 3'b000, -1, 8},
    '{4'd8,  16'd9, 6'b000001, 16'd4, 16'd0, 16'd0, 3'b001, 36, 8},
    '{4'd0,  16'd9, 6'b000010, 16'd3, 16'd0, 16'd0, 3'b101, 20, 1},
    '{4'd3,  16'd5, 6'b001110, 16'd5, 16'd2, 16'd0, 3'b000, 20, 6}
  };

  int cyc_bad;

  task automatic tick_cmp();
    @(negedge clk);
    if (pin_out !== ref_out() || pin_oe !== ref_oe()) begin
      if (cyc_bad == 0)
        $display("  first difference: pin_out %b/%b oe %b/%b (actual/expected)",
                 pin_out, ref_out(), pin_oe, ref_oe());
      cyc_bad++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R10: reset state
    wgm = 4'd14; top_val = 16'd9; cmp_mode = 6'b000010; cmp_val = {16'd0, 16'd0, 16'd3};
    port_val = 3'b111;
    repeat (3) @(negedge clk);
    check("R10", "pin_out in reset", pin_out, 3'b110);
    check("R10", "pin_oe in reset", pin_oe, 3'b001);

    for (int v = 0; v < NV; v++) begin
      automatic int win;
      automatic int hi = 0;
      do_reset();
      wgm = VT[v].sel; top_val = VT[v].top; cmp_mode = VT[v].fld;
      cmp_val = {VT[v].cc, VT[v].cb, VT[v].ca}; port_val = VT[v].port;
      win = is_dual(VT[v].sel) ? 4 * VT[v].top : 2 * (VT[v].top + 1);
      cyc_bad = 0;
      repeat (3 * win) tick_cmp();
      for (int k = 0; k < win; k++) begin
        tick_cmp();
        if (pin_out[0]) hi++;
      end
      check(rq(VT[v].req), $sformatf("vector %0d cycle mismatches", v), cyc_bad, 0);
      if (VT[v].hi_a >= 0)
        check(rq(VT[v].req), $sformatf("vector %0d high cycles of A", v), hi, VT[v].hi_a);
    end

    // R2: counter order seen through pin A toggling in selection 15 with compare 0
    do_reset();
    wgm = 4'd15; top_val = 16'd4; cmp_mode = 6'b000001; cmp_val = '0; port_val = 0;
    cyc_bad = 0;
    repeat (40) tick_cmp();
    check("R2", "toggle period tracking", cyc_bad, 0);

    // R9: mid-period compare change takes effect only after TOP
    do_reset();
    wgm = 4'd14; top_val = 16'd9; cmp_mode = 6'b000010; cmp_val = {32'd0, 16'd3}; port_val = 0;
    repeat (40) @(negedge clk);
    while (m_cnt != 16'd5) @(negedge clk);
    cmp_val[15:0] = 16'd7;
    while (m_cnt != 16'd8) @(negedge clk);
    check("R9", "pin A after late write, same period", pin_out[0], 1'b0);
    while (m_cnt != 16'd9) @(negedge clk);
    begin
      automatic int hi = 0;
      for (int k = 0; k < 10; k++) begin @(negedge clk); if (pin_out[0]) hi++; end
      check("R9", "high cycles in next period", hi, 7);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule